// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts every virtual address issued by a load/store pipeline into one of three outcomes before any translation lookaside buffer is consulted: the address is unmapped and its physical address is produced here, the address must be translated by the TLB, or the access is illegal and raises an address error. The outcome depends on the current privilege level, the exception-level and error-level status bits, and the per-mode enables that select 32-bit or 64-bit addressing.

All decode outputs are combinational from the request inputs, so the pipeline sees the answer in the same cycle. A request is marked by `req_valid`. There is no ready signal and no back-pressure: the decoder accepts one request every cycle it is offered. A registered `rsp_valid` copy of `req_valid` follows one cycle later. It lets a consumer that registers the decode outputs line its capture up with the request.

Top module: `vseg_decoder`

## Requirements
- R1: The effective privilege is kernel whenever `exl` or `erl` is 1, whatever `ksu` holds. Otherwise `ksu`=2'b00 is kernel, 2'b01 is supervisor and 2'b10 or 2'b11 is user.
- R2: The 64-bit enable in force is `kx` in kernel and `ux` in user or supervisor. When it is 0, `eff_vaddr` is bits 31:0 of `vaddr` sign-extended from bit 31, and all later decode steps use that value. When it is 1, `eff_vaddr` equals `vaddr`. `wide_mode` shows the enable in force.
- R3: In kernel with `erl`=1, an untruncated `vaddr` at or below 0x7FFFFFFF is unmapped, and `paddr` = `vaddr` AND 0x7FFFFFFF.
- R4: In kernel, an untruncated `vaddr` whose bits 63:62 are 2'b10 is unmapped, and `paddr` is bits 43:0 of `vaddr`. This test comes before sign-extension, so it applies even when `kx`=0.
- R5: In kernel, an `eff_vaddr` from 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF is unmapped, and `paddr` = `eff_vaddr` AND 0x1FFFFFFF.
- R6: An `eff_vaddr` at or below the user-segment top is sent to the TLB (`map_req`=1, `refill`=1). The top is 0x7FFFFFFF in 32-bit mode and 0xFFFFFFFFFF in 64-bit mode.
- R7: In kernel, an `eff_vaddr` above the user-segment top that R3 to R5 do not claim is sent to the TLB.
- R8: In user or supervisor, an `eff_vaddr` above the user-segment top raises `adr_err`, with `refill`=0. `err_code` is 2'b10 (store) for a write and 2'b01 (load) for a read. It is 2'b00 whenever there is no error.
- R9: `mode_unsup` is 1 exactly when the effective privilege is supervisor. Such a request is otherwise decoded as user.
- R10: While `req_valid`=1, exactly one of `map_req`, `direct` and `adr_err` is 1. While `req_valid`=0, all three are 0. `writable` equals `direct`, and `paddr` is 0 unless `direct` is 1.
- R11: `rsp_valid` is 0 after reset and equals the previous cycle's `req_valid` after every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| vaddr | input | 64 | Virtual address |
| ksu | input | 2 | Privilege field: 00 kernel, 01 supervisor, 10/11 user |
| exl | input | 1 | Exception-level status bit |
| erl | input | 1 | Error-level status bit |
| ux | input | 1 | 64-bit addressing enable for user and supervisor |
| kx | input | 1 | 64-bit addressing enable for kernel |
| is_write | input | 1 | 1 for a store, 0 for a load |
| map_req | output | 1 | Address must be translated by the TLB |
| direct | output | 1 | Address is unmapped; `paddr` is valid |
| adr_err | output | 1 | Address error |
| err_code | output | 2 | 00 none, 01 load error, 10 store error |
| refill | output | 1 | A TLB miss on this request would be a refill |
| writable | output | 1 | Unmapped result is read/write |
| paddr | output | 64 | Physical address for unmapped requests |
| eff_vaddr | output | 64 | Address after optional sign-extension |
| wide_mode | output | 1 | The 64-bit enable in force |
| mode_unsup | output | 1 | Effective privilege is supervisor |
| rsp_valid | output | 1 | Registered copy of `req_valid` |

## Verification
Each region is tried at both of its edges. The tests include 0x7FFFFFFF against 0x80000000, 0xFFFFFFFFFF against 0x10000000000, and the two ends of the sign-extended kseg window, so an off-by-one comparator or a wrong top constant shows up. The same address is replayed with only `kx`/`ux`, `erl`, `exl` or `ksu` changed, which separates the mode logic from the region logic. Addresses with junk in bits 63:32 under 32-bit mode, and xkphys addresses with `kx`=0, show whether sign-extension happens before or after the raw-address tests. Reads and writes of the same illegal address tell the load error code from the store code.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2
  } priv_e;

  typedef enum logic [1:0] {
    SEG_TLB    = 2'd0,
    SEG_DIRECT = 2'd1,
    SEG_FAULT  = 2'd2
  } seg_kind_e;

  localparam logic [1:0] ERR_NONE  = 2'b00;
  localparam logic [1:0] ERR_LOAD  = 2'b01;
  localparam logic [1:0] ERR_STORE = 2'b10;
endpackage

// File: rtl/vseg_mode.sv
module vseg_mode
  import vseg_pkg::*;
#(
  parameter int VA_W = 64
) (
  input  logic [1:0]      ksu,
  input  logic            exl,
  input  logic            erl,
  input  logic            ux,
  input  logic            kx,
  input  logic [VA_W-1:0] vaddr,
  output priv_e           priv,
  output logic            wide,
  output logic [VA_W-1:0] ext_va
);
  localparam int HI_W = VA_W - 32;

  always_comb begin
    if (exl || erl || ksu == 2'b00) priv = PRIV_KERNEL;
    else if (ksu == 2'b01)          priv = PRIV_SUPER;
    else                            priv = PRIV_USER;
  end

  assign wide   = (priv == PRIV_KERNEL) ? kx : ux;
  assign ext_va = wide ? vaddr : {{HI_W{vaddr[31]}}, vaddr[31:0]};
endmodule

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
#(
  parameter int VA_W        = 64,
  parameter int USEG_BITS   = 40,
  parameter int XKPHYS_BITS = 44
) (
  input  logic            kernel,
  input  logic            erl,
  input  logic            wide,
  input  logic            is_write,
  input  logic [VA_W-1:0] raw_va,
  input  logic [VA_W-1:0] ext_va,
  output seg_kind_e       kind,
  output logic [VA_W-1:0] pa,
  output logic [1:0]      err_code
);
  localparam logic [VA_W-1:0] TOP32     = {{(VA_W-31){1'b0}}, {31{1'b1}}};
  localparam logic [VA_W-1:0] TOP64     = {{(VA_W-USEG_BITS){1'b0}}, {USEG_BITS{1'b1}}};
  localparam logic [VA_W-1:0] XK_MASK   = {{(VA_W-XKPHYS_BITS){1'b0}}, {XKPHYS_BITS{1'b1}}};
  localparam logic [VA_W-1:0] KSEG_MASK = {{(VA_W-29){1'b0}}, {29{1'b1}}};
  localparam logic [VA_W-1:0] KSEG_LO   = {{(VA_W-32){1'b1}}, 32'h8000_0000};
  localparam logic [VA_W-1:0] KSEG_HI   = {{(VA_W-32){1'b1}}, 32'hBFFF_FFFF};

  logic [VA_W-1:0] useg_top;
  logic            erl_win;
  logic            xkphys_hit;
  logic            in_useg;
  logic            in_kseg;

  assign useg_top   = wide ? TOP64 : TOP32;
  assign erl_win    = kernel && erl && (raw_va <= TOP32);
  assign xkphys_hit = kernel && (raw_va[VA_W-1:VA_W-2] == 2'b10);
  assign in_useg    = (ext_va <= useg_top);
  assign in_kseg    = (ext_va >= KSEG_LO) && (ext_va <= KSEG_HI);

  always_comb begin
    kind     = SEG_TLB;
    pa       = '0;
    err_code = ERR_NONE;
    if (erl_win) begin
      kind = SEG_DIRECT;
      pa   = raw_va & TOP32;
    end else if (xkphys_hit) begin
      kind = SEG_DIRECT;
      pa   = raw_va & XK_MASK;
    end else if (in_useg) begin
      kind = SEG_TLB;
    end else if (kernel) begin
      if (in_kseg) begin
        kind = SEG_DIRECT;
        pa   = ext_va & KSEG_MASK;
      end
    end else begin
      kind     = SEG_FAULT;
      err_code = is_write ? ERR_STORE : ERR_LOAD;
    end
  end
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
  import vseg_pkg::*;
#(
  parameter int VA_W        = 64,
  parameter int USEG_BITS   = 40,
  parameter int XKPHYS_BITS = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      ksu,
  input  logic            exl,
  input  logic            erl,
  input  logic            ux,
  input  logic            kx,
  input  logic            is_write,
  output logic            map_req,
  output logic            direct,
  output logic            adr_err,
  output logic [1:0]      err_code,
  output logic            refill,
  output logic            writable,
  output logic [VA_W-1:0] paddr,
  output logic [VA_W-1:0] eff_vaddr,
  output logic            wide_mode,
  output logic            mode_unsup,
  output logic            rsp_valid
);
  priv_e           priv;
  seg_kind_e       kind;
  logic [VA_W-1:0] pa_raw;
  logic [1:0]      code_raw;

  vseg_mode #(.VA_W(VA_W)) u_mode (
    .ksu    (ksu),
    .exl    (exl),
    .erl    (erl),
    .ux     (ux),
    .kx     (kx),
    .vaddr  (vaddr),
    .priv   (priv),
    .wide   (wide_mode),
    .ext_va (eff_vaddr)
  );

  vseg_classify #(
    .VA_W        (VA_W),
    .USEG_BITS   (USEG_BITS),
    .XKPHYS_BITS (XKPHYS_BITS)
  ) u_classify (
    .kernel   (priv == PRIV_KERNEL),
    .erl      (erl),
    .wide     (wide_mode),
    .is_write (is_write),
    .raw_va   (vaddr),
    .ext_va   (eff_vaddr),
    .kind     (kind),
    .pa       (pa_raw),
    .err_code (code_raw)
  );

  assign map_req    = req_valid && (kind == SEG_TLB);
  assign direct     = req_valid && (kind == SEG_DIRECT);
  assign adr_err    = req_valid && (kind == SEG_FAULT);
  assign err_code   = req_valid ? code_raw : ERR_NONE;
  assign refill     = map_req;
  assign writable   = direct;
  assign paddr      = direct ? pa_raw : '0;
  assign mode_unsup = (priv == PRIV_SUPER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  // R10: one outcome per request, none when idle
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones({map_req, direct, adr_err}) == 1));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(map_req || direct || adr_err));
  // R11: response strobe trails the request by one cycle
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R8: address errors only outside kernel privilege
  a_r8_err_not_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    adr_err |-> (ksu != 2'b00 && !exl && !erl));
  // R8: error code nonzero exactly on an error, store code on writes
  a_r8_code_kind: assert property (@(posedge clk) disable iff (!rst_n)
    adr_err |-> (err_code == (is_write ? 2'b10 : 2'b01)));
  // R3/R4/R5: unmapped results only for kernel privilege
  a_r5_direct_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    direct |-> (ksu == 2'b00 || exl || erl));
  // R9: supervisor never reaches an unmapped window
  a_r9_unsup_not_direct: assert property (@(posedge clk) disable iff (!rst_n)
    mode_unsup |-> !direct);
endmodule

// File: tb/vseg_decoder_bench.sv
module vseg_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K_TLB = 0, K_DIR = 1, K_ERR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] vaddr = '0;
  logic [1:0]  ksu = 2'b00;
  logic        exl = 1'b0, erl = 1'b0, ux = 1'b0, kx = 1'b0, is_write = 1'b0;
  logic        map_req, direct, adr_err, refill, writable, wide_mode, mode_unsup, rsp_valid;
  logic [1:0]  err_code;
  logic [63:0] paddr, eff_vaddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vseg_decoder u_vseg_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .ksu(ksu), .exl(exl), .erl(erl), .ux(ux), .kx(kx), .is_write(is_write),
    .map_req(map_req), .direct(direct), .adr_err(adr_err), .err_code(err_code),
    .refill(refill), .writable(writable), .paddr(paddr), .eff_vaddr(eff_vaddr),
    .wide_mode(wide_mode), .mode_unsup(mode_unsup), .rsp_valid(rsp_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic e, input logic r,
                       input logic u, input logic kk, input logic w, input logic [63:0] va);
    @(negedge clk);
    ksu = k; exl = e; erl = r; ux = u; kx = kk; is_write = w; vaddr = va;
    req_valid = 1'b1;
    #1;
  endtask

  task automatic expect_out(input string req, input int kind, input logic [63:0] pa,
                            input logic [1:0] code);
    check({req, " outcome"}, {61'd0, adr_err, direct, map_req},
          (kind == K_TLB) ? 64'd1 : (kind == K_DIR) ? 64'd2 : 64'd4);
    check({req, " paddr"}, paddr, (kind == K_DIR) ? pa : 64'd0);
    check({req, " err_code"}, {62'd0, err_code}, {62'd0, code});
    check({req, " refill"}, {63'd0, refill}, {63'd0, kind == K_TLB});
    check({req, " writable"}, {63'd0, writable}, {63'd0, kind == K_DIR});
  endtask

  task automatic t_reset;
    check("R11 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_kernel32;
    drive(2'b00, 0, 0, 0, 0, 0, 64'h0000_0000_A012_3456);
    check("R2 sext eff_vaddr", eff_vaddr, 64'hFFFF_FFFF_A012_3456);
    check("R2 wide_mode kx", {63'd0, wide_mode}, 64'd0);
    expect_out("R5 kseg1", K_DIR, 64'h0012_3456, 2'b00);
    drive(2'b00, 0, 0, 0, 0, 1, 64'h0000_0000_8000_0000);
    expect_out("R5 kseg low edge", K_DIR, 64'd0, 2'b00);
    drive(2'b00, 0, 0, 0, 0, 0, 64'h0000_0000_BFFF_FFFF);
    expect_out("R5 kseg high edge", K_DIR, 64'h1FFF_FFFF, 2'b00);
    drive(2'b00, 0, 0, 0, 0, 0, 64'h0000_0000_C000_0000);
    expect_out("R7 kernel above kseg", K_TLB, 0, 2'b00);
    drive(2'b00, 0, 0, 0, 0, 0, 64'h0000_0000_0040_0000);
    expect_out("R6 kernel low", K_TLB, 0, 2'b00);
  endtask

  task automatic t_erl_window;
    drive(2'b10, 0, 1, 0, 0, 1, 64'h0000_0000_1234_5678);
    check("R1 erl forces kernel unsup", {63'd0, mode_unsup}, 64'd0);
    expect_out("R3 erl window", K_DIR, 64'h1234_5678, 2'b00);
    drive(2'b10, 0, 1, 0, 0, 0, 64'h0000_0000_7FFF_FFFF);
    expect_out("R3 erl top edge", K_DIR, 64'h7FFF_FFFF, 2'b00);
    drive(2'b10, 0, 1, 0, 0, 0, 64'h0000_0000_8000_0004);
    expect_out("R3 erl just above", K_DIR, 64'h4, 2'b00);
    drive(2'b10, 0, 0, 0, 0, 0, 64'h0000_0000_1234_5678);
    expect_out("R6 same addr no erl", K_TLB, 0, 2'b00);
  endtask

  task automatic t_xkphys;
    drive(2'b00, 0, 0, 0, 0, 0, 64'h9000_0ABC_DEF0_1234);
    expect_out("R4 xkphys kx0", K_DIR, 64'h0000_0ABC_DEF0_1234, 2'b00);
    drive(2'b00, 0, 0, 0, 1, 1, 64'hBFFF_FFFF_FFFF_FFFF);
    expect_out("R4 xkphys top", K_DIR, 64'h0000_0FFF_FFFF_FFFF, 2'b00);
    drive(2'b10, 0, 0, 1, 0, 1, 64'h9000_0000_0000_0000);
    expect_out("R8 user xkphys store", K_ERR, 0, 2'b10);
  endtask

  task automatic t_user;
    drive(2'b10, 0, 0, 0, 0, 0, 64'h0000_0000_7FFF_FFFF);
    expect_out("R6 user32 top", K_TLB, 0, 2'b00);
    drive(2'b10, 0, 0, 0, 0, 0, 64'h0000_0000_8000_0000);
    expect_out("R8 user32 load", K_ERR, 0, 2'b01);
    drive(2'b10, 0, 0, 0, 0, 1, 64'h0000_0000_8000_0000);
    expect_out("R8 user32 store", K_ERR, 0, 2'b10);
    drive(2'b11, 0, 0, 0, 0, 0, 64'hDEAD_BEEF_1234_5678);
    check("R2 junk high dropped", eff_vaddr, 64'h0000_0000_1234_5678);
    expect_out("R6 ksu11 user", K_TLB, 0, 2'b00);
    drive(2'b10, 0, 0, 1, 0, 0, 64'h0000_00FF_FFFF_FFFF);
    check("R2 wide_mode ux", {63'd0, wide_mode}, 64'd1);
    expect_out("R6 user64 top", K_TLB, 0, 2'b00);
    drive(2'b10, 0, 0, 1, 0, 1, 64'h0000_0100_0000_0000);
    expect_out("R8 user64 above", K_ERR, 0, 2'b10);
  endtask

  task automatic t_kernel64;
    drive(2'b00, 0, 0, 0, 1, 0, 64'hFFFF_FFFF_8000_0010);
    expect_out("R5 kernel64 kseg0", K_DIR, 64'h10, 2'b00);
    drive(2'b00, 0, 0, 0, 1, 0, 64'hC000_0000_0000_0000);
    expect_out("R7 kernel64 xkseg", K_TLB, 0, 2'b00);
    drive(2'b00, 0, 0, 0, 1, 0, 64'h0000_0100_0000_0000);
    expect_out("R7 kernel64 gap", K_TLB, 0, 2'b00);
    drive(2'b00, 0, 0, 1, 0, 0, 64'h0000_0000_1000_0000);
    check("R2 kernel ignores ux", {63'd0, wide_mode}, 64'd0);
  endtask

  task automatic t_super;
    drive(2'b01, 0, 0, 0, 0, 0, 64'h0000_0000_8000_0000);
    check("R9 supervisor flag", {63'd0, mode_unsup}, 64'd1);
    expect_out("R9 super as user", K_ERR, 0, 2'b01);
    drive(2'b01, 1, 0, 0, 0, 0, 64'h0000_0000_8000_0000);
    check("R1 exl forces kernel", {63'd0, mode_unsup}, 64'd0);
    expect_out("R1 exl kseg0", K_DIR, 64'd0, 2'b00);
  endtask

  task automatic t_strobe;
    drive(2'b00, 0, 0, 0, 0, 0, 64'h0000_0000_0000_1000);
    @(posedge clk); #1;
    check("R11 rsp after req", {63'd0, rsp_valid}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R10 idle outcome", {61'd0, adr_err, direct, map_req}, 64'd0);
    check("R10 idle paddr", paddr, 64'd0);
    check("R10 idle err_code", {62'd0, err_code}, 64'd0);
    @(posedge clk); #1;
    check("R11 rsp drops", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_n = 1'b1;
    t_kernel32();
    t_erl_window();
    t_xkphys();
    t_user();
    t_kernel64();
    t_super();
    t_strobe();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule